// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the stream of column addresses that a synchronous DRAM controller puts on the bus, one per beat. A request carries a starting column, a burst length code and an ordering bit. The block then emits one column per accepted beat. Short bursts wrap inside their aligned block, in either counting order or XOR order. The full-row mode sweeps the whole row, wrapping from the top column back to zero, until a stop strobe ends it.

Requests enter through a valid/ready handshake. Only one burst is held at a time, so `start_ready` is high exactly while no burst is active. A request offered while a burst is running simply waits. Beats leave through a second valid/ready handshake. While `out_valid` is high and `out_ready` is low, the beat is held: the column and the last flag do not change. The beat counter moves only on a handshake. The stop strobe is a plain control pin that acts only while a burst is active.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `out_valid` and `out_last` are 0 and `start_ready` is 1.
- R2: A request is taken in any cycle in which `start_valid` and `start_ready` are both high. On the next cycle `out_valid` is 1 and `out_col` equals the requested start column. While a burst is active `start_ready` is 0 and a request offered then has no effect on the running burst.
- R3: The 3-bit length code `len_code` gives the length: 3'b000 is 1, 3'b001 is 2, 3'b010 is 4, 3'b011 is 8 and 3'b111 is full row (512 beats). The codes 3'b100, 3'b101 and 3'b110 give length 1.
- R4: When `ilv_mode` is 0, beat n of a burst of length L (with L below full row) keeps all bits of the start column above bit log2(L)-1. Its low log2(L) bits are (start + n) mod L.
- R5: When `ilv_mode` is 1, beat n of a burst of length L (with L below full row) keeps the upper bits of the start column. Its low log2(L) bits are the start's low bits XOR n.
- R6: In full-row mode `ilv_mode` is ignored and beat n is (start + n) mod 512. The burst continues past 512 beats until stopped, and `out_last` stays 0 throughout.
- R7: `out_last` is 1 on, and only on, the final beat of a burst that is not full row. Once that beat is handed over, `out_valid` is 0 on the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle shows the same `out_col` and `out_last` with `out_valid` still 1, unless `stop` was high.
- R9: If `stop` is high in a cycle in which a burst is active, `out_valid` is 0 from the next cycle. This holds whether the beat was stalled or handed over, and also on the final beat. A beat handed over in that same cycle counts as delivered.
- R10: `stop` has no effect while no burst is active, including in the cycle in which a request is taken. That burst then runs normally.
- R11: In the cycle after a burst ends, by its final beat or by `stop`, `start_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Burst request offered |
| start_ready | output | 1 | Block can take a request (no burst active) |
| start_col | input | 9 | Starting column of the request |
| len_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | Ordering: 0 counting, 1 XOR |
| stop | input | 1 | Ends an active burst on the next clock |
| out_valid | output | 1 | A beat column is present |
| out_ready | input | 1 | Consumer takes the beat |
| out_col | output | 9 | Column of the current beat |
| out_last | output | 1 | Current beat is the final one |

## Verification
Two events can land in one clock edge. The first case is a stop arriving in the same cycle as the handshake of the final beat. The bench raises `stop` exactly on the last beat of a length-4 burst and on a stalled mid-burst beat. It judges that `out_valid` drops on the very next cycle, with no extra beat, and that `start_ready` is back. The second case is a stop arriving in the same cycle as a request being taken while idle. The bench raises `stop` and `start_valid` together and expects the resulting length-2 burst to deliver both of its columns unchanged.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned COL_W  = 9;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_ROW  = 3'b111
  } len_code_e;

  // log2 of the fixed lengths; reserved codes fall back to one beat
  function automatic int unsigned code_to_log2(input logic [CODE_W-1:0] c);
    case (c)
      LEN_2:   return 1;
      LEN_4:   return 2;
      LEN_8:   return 3;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int unsigned W = COL_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [W-1:0]      wrap_mask,
  output logic              full_row
);
  int unsigned lg;

  always_comb begin
    lg       = code_to_log2(code);
    full_row = (code == LEN_ROW);
  end

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign wrap_mask[i] = full_row || (lg > i);
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] beat,
  input  logic [W-1:0] wrap_mask,
  input  logic         xor_order,
  output logic [W-1:0] col
);
  logic [W-1:0] sum;
  assign sum = base + beat;

  // per bit: bits outside the wrap window keep the base value
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic lane;
    assign lane   = xor_order ? (base[i] ^ beat[i]) : sum[i];
    assign col[i] = wrap_mask[i] ? lane : base[i];
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_req,
  input  logic         stop,
  input  logic         beat_fire,
  input  logic [W-1:0] req_base,
  input  logic [W-1:0] req_mask,
  input  logic         req_xor,
  input  logic         req_full,
  output logic         active,
  output logic [W-1:0] beat,
  output logic [W-1:0] base_q,
  output logic [W-1:0] mask_q,
  output logic         xor_q,
  output logic         last_beat
);
  logic full_q;

  assign last_beat = active && !full_q && (beat == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      base_q <= '0;
      mask_q <= '0;
      xor_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (!active) begin
      if (take_req) begin
        active <= 1'b1;
        beat   <= '0;
        base_q <= req_base;
        mask_q <= req_mask;
        xor_q  <= req_xor && !req_full;
        full_q <= req_full;
      end
    end else begin
      if (beat_fire) beat <= beat + 1'b1;
      if (stop || (beat_fire && last_beat)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              ilv_mode,
  input  logic              stop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COL_W-1:0]  out_col,
  output logic              out_last
);
  logic             active, last_beat, xor_q, req_full;
  logic [COL_W-1:0] beat, base_q, mask_q, req_mask;
  logic             take_req, beat_fire;

  assign start_ready = !active;
  assign take_req    = start_valid && start_ready;
  assign out_valid   = active;
  assign beat_fire   = active && out_ready;
  assign out_last    = last_beat;

  bcs_len_decode #(.W(COL_W)) u_dec (
    .code      (len_code),
    .wrap_mask (req_mask),
    .full_row  (req_full)
  );

  bcs_ctrl #(.W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_req  (take_req),
    .stop      (stop),
    .beat_fire (beat_fire),
    .req_base  (start_col),
    .req_mask  (req_mask),
    .req_xor   (ilv_mode),
    .req_full  (req_full),
    .active    (active),
    .beat      (beat),
    .base_q    (base_q),
    .mask_q    (mask_q),
    .xor_q     (xor_q),
    .last_beat (last_beat)
  );

  bcs_col_gen #(.W(COL_W)) u_gen (
    .base      (base_q),
    .beat      (beat),
    .wrap_mask (mask_q),
    .xor_order (xor_q),
    .col       (out_col)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic [COL_W-1:0]  start_col,
  input logic              stop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COL_W-1:0]  out_col,
  input logic              out_last
);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> (out_valid && out_col == $past(start_col)));

  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !stop) |=> (out_valid && $stable(out_col) && $stable(out_last)));

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && stop) |=> !out_valid);

  a_r10_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !start_valid && stop) |=> !out_valid);

  a_r11_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> start_ready);
endmodule

bind burst_col_seq bcs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .start_col   (start_col),
  .stop        (stop),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_col     (out_col),
  .out_last    (out_last)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic       start_ready;
  logic [8:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       ilv_mode = 1'b0;
  logic       stop = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [8:0] out_col;
  logic       out_last;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_col_seq u_burst_col_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input logic [2:0] c, input bit ilv, input int n);
    int l = blen(c);
    int m = l - 1;
    if (l == 512) return (s + n) % 512;
    if (ilv) return (s & ~m) | ((s ^ n) & m);
    return (s & ~m) | ((s + n) & m);
  endfunction

  task automatic offer(input int s, input logic [2:0] c, input bit ilv);
    @(negedge clk);
    start_valid = 1'b1; start_col = 9'(s); len_code = c; ilv_mode = ilv;
    chk("R2 ready before request", int'(start_ready), 1);
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  // run beats with ready held high; optional stop on the last one issued
  task automatic run_burst(input string req, input int s, input logic [2:0] c,
                           input bit ilv, input int beats, input bit stop_end);
    int l = blen(c);
    offer(s, c, ilv);
    out_ready = 1'b1;
    for (int k = 0; k < beats; k++) begin
      chk({req, " valid"}, int'(out_valid), 1);
      chk({req, " col"}, int'(out_col), exp_col(s, c, ilv, k));
      chk({"R7 last ", req}, int'(out_last), (l != 512 && k == l - 1) ? 1 : 0);
      if (stop_end && k == beats - 1) stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end
    chk({"R11 idle after ", req}, int'(out_valid), 0);
    chk({"R11 ready after ", req}, int'(start_ready), 1);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_last", int'(out_last), 0);
    chk("R1 start_ready", int'(start_ready), 1);
  endtask

  task automatic t_stall;
    offer(9'h046, 3'b010, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk("R8 stalled col", int'(out_col), 9'h046);
      chk("R8 stalled valid", int'(out_valid), 1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R8 col after stall", int'(out_col), exp_col(9'h046, 3'b010, 1'b0, k));
      @(negedge clk);
    end
    chk("R8 done", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  task automatic t_stop_stalled;
    offer(9'h100, 3'b011, 1'b1);
    out_ready = 1'b0;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9 stop while stalled", int'(out_valid), 0);
    chk("R11 ready after stalled stop", int'(start_ready), 1);
  endtask

  task automatic t_stop_with_start;
    @(negedge clk);
    start_valid = 1'b1; stop = 1'b1; start_col = 9'h0A3; len_code = 3'b001; ilv_mode = 1'b0;
    @(negedge clk);
    start_valid = 1'b0; stop = 1'b0; out_ready = 1'b1;
    chk("R10 burst survives stop", int'(out_valid), 1);
    chk("R10 beat0", int'(out_col), 9'h0A3);
    @(negedge clk);
    chk("R10 beat1", int'(out_col), 9'h0A2);
    chk("R10 last", int'(out_last), 1);
    @(negedge clk);
    chk("R10 ends", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  task automatic t_idle_stop;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R10 idle stop", int'(out_valid), 0);
    chk("R10 idle stop ready", int'(start_ready), 1);
  endtask

  task automatic t_busy_request;
    offer(9'h011, 3'b010, 1'b0);
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      start_valid = (k < 3); start_col = 9'h1F0; len_code = 3'b111;
      if (k > 0) chk("R2 not ready while busy", int'(start_ready), 0);
      chk("R2 busy col", int'(out_col), exp_col(9'h011, 3'b010, 1'b0, k));
      @(negedge clk);
    end
    start_valid = 1'b0;
    chk("R2 busy request dropped", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_burst("R4 seq len8", 9'h0D5, 3'b011, 1'b0, 8, 1'b0);
    run_burst("R4 seq len4", 9'h1FE, 3'b010, 1'b0, 4, 1'b0);
    run_burst("R5 ilv len8", 9'h0D5, 3'b011, 1'b1, 8, 1'b0);
    run_burst("R5 ilv len2", 9'h031, 3'b001, 1'b1, 2, 1'b0);
    run_burst("R3 len1", 9'h123, 3'b000, 1'b0, 1, 1'b0);
    run_burst("R3 code4", 9'h077, 3'b100, 1'b1, 1, 1'b0);
    run_burst("R3 code5", 9'h078, 3'b101, 1'b0, 1, 1'b0);
    run_burst("R3 code6", 9'h079, 3'b110, 1'b1, 1, 1'b0);
    run_burst("R6 full row", 9'h1FC, 3'b111, 1'b1, 520, 1'b1);
    run_burst("R9 stop final", 9'h00C, 3'b010, 1'b0, 4, 1'b1);
    run_burst("R9 stop mid", 9'h020, 3'b011, 1'b0, 3, 1'b1);
    t_stall();
    t_stop_stalled();
    t_stop_with_start();
    t_idle_stop();
    t_busy_request();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule